// File: doc/BRIEF.md
# Directory Coherence Home Tracker

This block is the home-node bookkeeping for a small group of cache lines shared by several processors. For every line it keeps a holder mask, with one bit for each processor that has a copy, and a flag that marks a single holder as the exclusive owner. Coherence traffic is aimed only at the processors named in that mask. Nothing is broadcast and nothing is snooped.

Each request names the requesting processor, the line index and the kind of access, which is either a shared read or an exclusive write. A request that conflicts with no other holder is granted in the next cycle. Any other request starts an invalidation sweep. The sweep sends one invalidate per cycle to the holders that must give up the line. When every one of them has acknowledged, the sweep rewrites the entry and issues the grant.

While a sweep is in progress, further requests to that line are held off through `req_ready`. Requests to other lines still go through if they can be granted without invalidations.

Top module: `dirtrk_home`

## Requirements
- R1: After reset all entries are empty and `req_ready` is high, while `inv_valid` and `gnt_valid` are low.
- R2: A shared read (`req_kind`=0) to a line that no other processor owns exclusively is granted one cycle after acceptance with `gnt_excl`=0, and the requester is added to the holder mask.
- R3: An exclusive write (`req_kind`=1) to a line that other processors hold starts invalidations in the cycle after acceptance. It sends exactly one invalidate per cycle, to each holder other than the requester, lowest processor index first, and `inv_line` gives the line index.
- R4: The grant for an invalidating request appears two cycles after the cycle in which the last outstanding acknowledgement is presented. After a write, the entry holds only the requester, flagged exclusive (`gnt_excl`=1).
- R5: A write to a line held by nobody else, or re-requested by its exclusive owner, is granted one cycle after acceptance with `gnt_excl`=1. A read by the exclusive owner keeps its exclusive state.
- R6: A read of a line that another processor owns exclusively invalidates that owner. After the owner acknowledges, the read is granted with `gnt_excl`=0, and the requester becomes the only holder.
- R7: During a sweep, any request to the line being swept sees `req_ready` low. A request to another line that needs no invalidation is accepted and granted.
- R8: During a sweep, any request that would itself need invalidations sees `req_ready` low.
- R9: An acknowledgement from a processor whose invalidate has not yet been issued, or that has none outstanding, is not counted.
- R10: `inv_valid` carries at most one set bit per cycle, and it is never the requester's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 1 | 0 = shared read, 1 = exclusive write |
| req_proc | input | PROC_W | Requesting processor index |
| req_line | input | LINE_W | Line index |
| inv_valid | output | NUM_PROCS | One-hot invalidate to a processor |
| inv_line | output | LINE_W | Line being invalidated |
| inv_ack | input | NUM_PROCS | Per-processor invalidate acknowledgement |
| gnt_valid | output | 1 | Grant pulse |
| gnt_proc | output | PROC_W | Processor granted |
| gnt_line | output | LINE_W | Line granted |
| gnt_excl | output | 1 | Granted processor now holds the line exclusively |

## Verification
A request that needs no invalidation produces a grant one cycle after the edge that accepts it. For a sweep, the first invalidate is due in that same cycle and each later one a cycle after its predecessor, and the grant comes two cycles after the last counted acknowledgement. Inputs change on the falling edge and outputs are sampled on the falling edge, so each check reads the cycle in which the value counted above is due. The checks also include the cycles in between, where the grant must still be absent even though an acknowledgement came early or from a processor with nothing outstanding.

// File: rtl/dirtrk_pkg.sv
package dirtrk_pkg;

    localparam int unsigned MAX_PROCS = 32;

    typedef enum logic {
        REQ_SHARE = 1'b0,
        REQ_OWN   = 1'b1
    } req_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dirtrk_store.sv
module dirtrk_store #(
    parameter int unsigned WIDTH     = 5,
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W   = dirtrk_pkg::idx_width(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_idx,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_idx,
    input  logic [WIDTH-1:0]  wr_data
);

    logic [WIDTH-1:0] mem [NUM_LINES];

    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/dirtrk_decide.sv
module dirtrk_decide
    import dirtrk_pkg::*;
#(
    parameter int unsigned NUM_PROCS = 4,
    localparam int unsigned PROC_W   = idx_width(NUM_PROCS)
) (
    input  logic [NUM_PROCS:0]   cur,
    input  req_kind_e            kind,
    input  logic [PROC_W-1:0]    proc,
    output logic [NUM_PROCS-1:0] targets,
    output logic [NUM_PROCS:0]   final_entry,
    output logic                 grant_excl
);

    typedef logic [NUM_PROCS-1:0] mask_t;
    typedef struct packed {
        mask_t holders;
        logic  excl;
    } entry_t;

    entry_t cur_e;
    entry_t fin_e;
    mask_t  me;
    mask_t  others;

    assign cur_e       = entry_t'(cur);
    assign final_entry = fin_e;

    always_comb begin
        me         = mask_t'(1) << proc;
        others     = cur_e.holders & ~me;
        targets    = '0;
        fin_e      = cur_e;
        grant_excl = 1'b0;
        if (kind == REQ_OWN) begin
            // every other holder must drop the line before ownership moves
            targets      = others;
            fin_e.holders = me;
            fin_e.excl    = 1'b1;
            grant_excl   = 1'b1;
        end else if (cur_e.excl && (others != '0)) begin
            // recall the exclusive owner, requester becomes sole sharer
            targets      = others;
            fin_e.holders = me;
            fin_e.excl    = 1'b0;
        end else if (cur_e.excl) begin
            // owner re-reading its own line keeps exclusivity
            grant_excl   = 1'b1;
        end else begin
            fin_e.holders = cur_e.holders | me;
            fin_e.excl    = 1'b0;
        end
    end

endmodule

// File: rtl/dirtrk_invseq.sv
module dirtrk_invseq
    import dirtrk_pkg::*;
#(
    parameter int unsigned NUM_PROCS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NUM_PROCS-1:0] targets,
    input  logic [NUM_PROCS-1:0] ack,
    output logic [NUM_PROCS-1:0] inv,
    output logic                 busy,
    output logic                 done
);

    typedef logic [NUM_PROCS-1:0] mask_t;

    function automatic mask_t lowest(input mask_t m);
        return m & (~m + mask_t'(1));
    endfunction

    seq_state_e st_q;
    mask_t      to_send_q;
    mask_t      pending_q;
    mask_t      inv_q;
    mask_t      first;
    mask_t      nxt;
    mask_t      sent;

    always_comb begin
        first = lowest(targets);
        nxt   = lowest(to_send_q);
        sent  = pending_q & ~to_send_q;
    end

    assign inv  = inv_q;
    assign busy = (st_q == SEQ_WAIT);
    assign done = (st_q == SEQ_WAIT) && (pending_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SEQ_IDLE;
            to_send_q <= '0;
            pending_q <= '0;
            inv_q     <= '0;
        end else if (start) begin
            st_q      <= SEQ_WAIT;
            inv_q     <= first;
            to_send_q <= targets & ~first;
            pending_q <= targets;
        end else begin
            inv_q     <= nxt;
            to_send_q <= to_send_q & ~nxt;
            // only acknowledgements for invalidates already issued count
            pending_q <= pending_q & ~(ack & sent);
            if (done) begin
                st_q <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/dirtrk_home.sv
module dirtrk_home
    import dirtrk_pkg::*;
#(
    parameter int unsigned NUM_PROCS = 4,
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned PROC_W   = idx_width(NUM_PROCS),
    localparam int unsigned LINE_W   = idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_kind,
    input  logic [PROC_W-1:0]    req_proc,
    input  logic [LINE_W-1:0]    req_line,
    output logic [NUM_PROCS-1:0] inv_valid,
    output logic [LINE_W-1:0]    inv_line,
    input  logic [NUM_PROCS-1:0] inv_ack,
    output logic                 gnt_valid,
    output logic [PROC_W-1:0]    gnt_proc,
    output logic [LINE_W-1:0]    gnt_line,
    output logic                 gnt_excl
);

    localparam int unsigned ENTRY_W = NUM_PROCS + 1;

    typedef struct packed {
        logic [NUM_PROCS-1:0] holders;
        logic                 excl;
    } entry_t;

    typedef struct packed {
        logic              valid;
        logic [PROC_W-1:0] proc;
        logic [LINE_W-1:0] line;
        logic              excl;
    } grant_t;

    entry_t               rd_entry;
    entry_t               final_entry;
    entry_t               busy_final_q;
    entry_t               wr_data;
    logic [NUM_PROCS-1:0] targets;
    logic                 grant_excl;
    logic                 needs_inv;
    logic                 seq_busy;
    logic                 seq_done;
    logic                 accept;
    logic                 wr_en;
    logic [LINE_W-1:0]    wr_idx;
    logic [LINE_W-1:0]    busy_line_q;
    logic [PROC_W-1:0]    busy_proc_q;
    logic                 busy_gexcl_q;
    grant_t               gnt_q;
    req_kind_e            kind;

    assign kind = req_kind_e'(req_kind);

    dirtrk_store #(
        .WIDTH     (ENTRY_W),
        .NUM_LINES (NUM_LINES)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_line),
        .rd_data (rd_entry),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    dirtrk_decide #(
        .NUM_PROCS (NUM_PROCS)
    ) u_decide (
        .cur         (rd_entry),
        .kind        (kind),
        .proc        (req_proc),
        .targets     (targets),
        .final_entry (final_entry),
        .grant_excl  (grant_excl)
    );

    assign needs_inv = (targets != '0);

    // stall: line under sweep, a second sweep, or the grant slot taken
    assign req_ready = !seq_busy ||
                       (!seq_done && (req_line != busy_line_q) && !needs_inv);
    assign accept    = req_valid && req_ready;

    dirtrk_invseq #(
        .NUM_PROCS (NUM_PROCS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept && needs_inv),
        .targets (targets),
        .ack     (inv_ack),
        .inv     (inv_valid),
        .busy    (seq_busy),
        .done    (seq_done)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = req_line;
        wr_data = final_entry;
        if (seq_done) begin
            wr_en   = 1'b1;
            wr_idx  = busy_line_q;
            wr_data = busy_final_q;
        end else if (accept && !needs_inv) begin
            wr_en   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_line_q  <= '0;
            busy_proc_q  <= '0;
            busy_final_q <= '0;
            busy_gexcl_q <= 1'b0;
        end else if (accept && needs_inv) begin
            busy_line_q  <= req_line;
            busy_proc_q  <= req_proc;
            busy_final_q <= final_entry;
            busy_gexcl_q <= grant_excl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= '0;
        end else if (seq_done) begin
            gnt_q <= '{valid: 1'b1, proc: busy_proc_q, line: busy_line_q, excl: busy_gexcl_q};
        end else if (accept && !needs_inv) begin
            gnt_q <= '{valid: 1'b1, proc: req_proc, line: req_line, excl: grant_excl};
        end else begin
            gnt_q.valid <= 1'b0;
        end
    end

    assign inv_line  = busy_line_q;
    assign gnt_valid = gnt_q.valid;
    assign gnt_proc  = gnt_q.proc;
    assign gnt_line  = gnt_q.line;
    assign gnt_excl  = gnt_q.excl;

endmodule

// File: rtl/dirtrk_home_chk.sv
module dirtrk_home_chk #(
    parameter int unsigned NUM_PROCS = 4,
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned PROC_W   = dirtrk_pkg::idx_width(NUM_PROCS),
    localparam int unsigned LINE_W   = dirtrk_pkg::idx_width(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [LINE_W-1:0]    req_line,
    input logic [NUM_PROCS-1:0] inv_valid,
    input logic                 gnt_valid,
    input logic                 busy,
    input logic [LINE_W-1:0]    busy_line,
    input logic [PROC_W-1:0]    busy_proc,
    input logic                 needs_inv
);

    logic [NUM_PROCS-1:0] req_bit;
    assign req_bit = {{(NUM_PROCS-1){1'b0}}, 1'b1} << busy_proc;

    // R10: one invalidate per cycle at most
    p_inv_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(inv_valid));

    // R10: the requester is never invalidated by its own sweep
    p_inv_not_req_r10: assert property (@(posedge clk) disable iff (rst)
        (inv_valid != '0) |-> ((inv_valid & req_bit) == '0));

    // R3: invalidates only while a sweep is open
    p_inv_in_sweep_r3: assert property (@(posedge clk) disable iff (rst)
        (inv_valid != '0) |-> busy);

    // R7: the swept line is back-pressured
    p_stall_line_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && (req_line == busy_line)) |-> !req_ready);

    // R8: no second sweep while one is open
    p_stall_sweep_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && needs_inv) |-> !req_ready);

    // R2: conflict-free request is granted next cycle
    p_fast_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !needs_inv) |=> gnt_valid);

endmodule

bind dirtrk_home dirtrk_home_chk #(
    .NUM_PROCS (NUM_PROCS),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_line  (req_line),
    .inv_valid (inv_valid),
    .gnt_valid (gnt_valid),
    .busy      (seq_busy),
    .busy_line (busy_line_q),
    .busy_proc (busy_proc_q),
    .needs_inv (needs_inv)
);

// File: tb/dirtrk_home_bench.sv
`timescale 1ns/1ps
module dirtrk_home_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_kind = 1'b0;
    logic [1:0] req_proc = '0;
    logic [2:0] req_line = '0;
    logic [3:0] inv_valid;
    logic [2:0] inv_line;
    logic [3:0] inv_ack = '0;
    logic       gnt_valid;
    logic [1:0] gnt_proc;
    logic [2:0] gnt_line;
    logic       gnt_excl;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dirtrk_home u_dirtrk_home (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_proc(req_proc), .req_line(req_line),
        .inv_valid(inv_valid), .inv_line(inv_line), .inv_ack(inv_ack),
        .gnt_valid(gnt_valid), .gnt_proc(gnt_proc), .gnt_line(gnt_line),
        .gnt_excl(gnt_excl)
    );

    // {kind, proc[1:0], line[2:0], expected gnt_excl}; none needs invalidation
    localparam logic [6:0] VEC [8] = '{
        7'b0_00_000_0,  // R2 read p0 L0
        7'b0_01_000_0,  // R2 read p1 L0
        7'b0_10_000_0,  // R2 read p2 L0
        7'b1_11_101_1,  // R5 write p3 to empty L5
        7'b0_11_101_1,  // R5 owner p3 rereads L5
        7'b1_01_110_1,  // R5 write p1 L6
        7'b1_01_110_1,  // R5 owner p1 rewrites L6
        7'b0_10_111_0   // R2 read p2 L7
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_gnt(input string tag, input int p, input int l, input int e);
        chk(gnt_valid == 1'b1, {tag, " gnt_valid"}, gnt_valid, 1);
        chk(gnt_proc == p, {tag, " gnt_proc"}, gnt_proc, p);
        chk(gnt_line == l, {tag, " gnt_line"}, gnt_line, l);
        chk(gnt_excl == e, {tag, " gnt_excl"}, gnt_excl, e);
    endtask

    task automatic drive(input logic k, input int p, input int l);
        req_valid = 1'b1;
        req_kind  = k;
        req_proc  = 2'(p);
        req_line  = 3'(l);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(inv_valid == 4'd0, "R1 inv", inv_valid, 0);
        chk(gnt_valid == 1'b0, "R1 gnt", gnt_valid, 0);

        // table of conflict-free requests
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drive(VEC[i][6], int'(VEC[i][5:4]), int'(VEC[i][3:1]));
            #1;
            chk(req_ready == 1'b1, "R2/R5 ready", req_ready, 1);
            @(negedge clk);
            req_valid = 1'b0;
            chk_gnt("R2/R5 vec", int'(VEC[i][5:4]), int'(VEC[i][3:1]), int'(VEC[i][0]));
        end

        // R3: write by p1 to L0 held by p0,p1,p2
        @(negedge clk);
        drive(1'b1, 1, 0);
        #1;
        chk(req_ready == 1'b1, "R3 ready", req_ready, 1);
        @(negedge clk);
        chk(inv_valid == 4'b0001, "R3 first inv", inv_valid, 1);
        chk(inv_line == 3'd0, "R3 inv_line", inv_line, 0);
        inv_ack = 4'b0100;               // R9 premature ack from p2
        drive(1'b0, 0, 0);
        #1;
        chk(req_ready == 1'b0, "R7 same line stall", req_ready, 0);
        @(negedge clk);
        chk(inv_valid == 4'b0100, "R3 second inv", inv_valid, 4);
        inv_ack = 4'b0000;
        drive(1'b0, 0, 7);
        #1;
        chk(req_ready == 1'b1, "R7 other line ready", req_ready, 1);
        @(negedge clk);
        chk_gnt("R7 other line", 0, 7, 0);
        chk(inv_valid == 4'b0000, "R3 no third inv", inv_valid, 0);
        drive(1'b1, 0, 7);               // L7 holds p2,p0: needs sweep
        inv_ack = 4'b1000;               // R9 ack with nothing outstanding
        #1;
        chk(req_ready == 1'b0, "R8 second sweep stall", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        inv_ack = 4'b0001;
        chk(gnt_valid == 1'b0, "R4 no early gnt", gnt_valid, 0);
        @(negedge clk);
        inv_ack = 4'b0100;
        chk(gnt_valid == 1'b0, "R9 premature ack not counted", gnt_valid, 0);
        @(negedge clk);
        inv_ack = 4'b0000;
        chk(gnt_valid == 1'b0, "R4 gnt not yet", gnt_valid, 0);
        @(negedge clk);
        chk_gnt("R4 sweep grant", 1, 0, 1);

        // R4: L0 now holds only p1; write by p3 invalidates p1 only
        @(negedge clk);
        drive(1'b1, 3, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(inv_valid == 4'b0010, "R4 sole holder inv", inv_valid, 2);
        inv_ack = 4'b0010;
        @(negedge clk);
        inv_ack = 4'b0000;
        chk(inv_valid == 4'b0000, "R10 single inv", inv_valid, 0);
        @(negedge clk);
        chk_gnt("R4 second grant", 3, 0, 1);

        // R6: read p0 of L5 owned by p3
        @(negedge clk);
        drive(1'b0, 0, 5);
        @(negedge clk);
        req_valid = 1'b0;
        chk(inv_valid == 4'b1000, "R6 recall owner", inv_valid, 8);
        chk(inv_line == 3'd5, "R6 inv_line", inv_line, 5);
        inv_ack = 4'b1000;
        @(negedge clk);
        inv_ack = 4'b0000;
        chk(gnt_valid == 1'b0, "R6 gnt not yet", gnt_valid, 0);
        @(negedge clk);
        chk_gnt("R6 recall grant", 0, 5, 0);

        // R6: L5 now holds only p0; write by p2 invalidates p0 alone
        @(negedge clk);
        drive(1'b1, 2, 5);
        @(negedge clk);
        req_valid = 1'b0;
        chk(inv_valid == 4'b0001, "R6 owner dropped", inv_valid, 1);
        inv_ack = 4'b0001;
        @(negedge clk);
        inv_ack = 4'b0000;
        @(negedge clk);
        chk_gnt("R6 follow-up grant", 2, 5, 1);

        @(negedge clk);
        chk(gnt_valid == 1'b0, "R4 grant is a pulse", gnt_valid, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule